// File: doc/BRIEF.md
# Exception and Interrupt Control Unit

This block owns the three machine-control registers that a processor core consults when it traps: the mode/enable register (Status), the trap-reason register (Cause) and the return-address register (EPC). The core's pipeline presents a trap request carrying a 5-bit reason code, the faulting program counter, a flag saying the faulting instruction sat in a branch delay slot, and the number of the coprocessor involved. On that request the unit pushes a three-deep kernel/user and interrupt-enable stack, records the reason, the delay-slot flag and the coprocessor number, stores the return address, and presents the handler entry address. A return-from-exception strobe pops the stack.

Six hardware interrupt lines are sampled into the pending field of Cause every cycle and merged with two software-settable pending bits. An interrupt request goes out when the current enable bit is set and any pending bit is also unmasked. Software reaches the registers by register number (12, 13 and 14) through a read/write port, with fixed write masks. Reason codes: 0 interrupt, 1 TLB modify, 2 TLB miss on load/fetch, 3 TLB miss on store, 4 address error on load/fetch, 5 address error on store, 6 instruction bus error, 7 data bus error, 8 syscall, 9 breakpoint, 10 reserved instruction, 11 coprocessor unusable, 12 overflow.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After synchronous reset, Status reads 0x00400000 (bootstrap vector select, bit 22, set), Cause and EPC read 0, and `irq_req` is low.
- R2: A software write to register 12 stores the written value ANDed with 0xF27FFF3F; masked bits read as zero.
- R3: A software write to register 13 changes only Cause bits 9..8; Cause bits 15..10 equal the value `hw_irq` had at the previous clock edge, every cycle after reset.
- R4: On a trap request, Status bits 5..0 become the old bits 3..0 shifted up by two, with bits 1..0 (current KU, current IE) cleared; other Status bits are kept.
- R5: On a trap request, Cause bits 6..2 take the reason code, bits 29..28 the coprocessor number and bit 31 the delay-slot flag; bits 9..8 are kept.
- R6: On a trap request, EPC takes the faulting PC, or the faulting PC minus 4 when the delay-slot flag is set.
- R7: On a return-from-exception strobe, Status bits 3..0 take the old bits 5..2 and bits 5..4 stay as they were.
- R8: `irq_req` is high exactly when Status bit 0 is 1 and (Cause bits 15..8 AND Status bits 15..8) is nonzero.
- R9: `handler_vec` is 0x80000080 with Status bit 22 clear and 0xBFC00180 with it set; when `exc_user_miss` is high the low offset is 0x000 instead of 0x080 (0x80000000 / 0xBFC00100).
- R10: A trap request in the same cycle as a return strobe or a software write wins: the strobe and the write have no effect on Status, Cause bits 9..8 or EPC. A return strobe in the same cycle as a software write wins over the write.
- R11: Reads of any register number other than 12, 13 and 14 return zero, and writes to them change none of the three registers.
- R12: A software write to register 14 stores the full 32-bit value in EPC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid | input | 1 | Trap request strobe |
| exc_code | input | 5 | Trap reason code |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_in_delay | input | 1 | Faulting instruction is in a branch delay slot |
| exc_cop | input | 2 | Coprocessor number for coprocessor-unusable traps |
| exc_user_miss | input | 1 | Trap is a TLB miss on a user-segment address |
| rfe | input | 1 | Return-from-exception strobe |
| reg_wr | input | 1 | Software register write strobe |
| reg_addr | input | 5 | Software register number |
| reg_wdata | input | 32 | Software write data |
| hw_irq | input | 6 | Hardware interrupt lines |
| reg_rdata | output | 32 | Software read data for `reg_addr` |
| irq_req | output | 1 | Interrupt request to the pipeline |
| handler_vec | output | 32 | Handler entry address |

## Verification
Two functions collide when a trap request lands in the same cycle as a software register write or a return strobe, so the bench drives those pairs together: a trap with a Status write that would set different stack bits, a trap with a Cause software-bit write, a trap with an EPC write, and a trap with a return strobe. The cycle-accurate reference model applies the stated precedence (trap over return over write), and the following read of each register must show the trap's effect only. A return strobe paired with a Status write is judged the same way.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned CODE_W   = 5;
    localparam int unsigned REGNO_W  = 5;
    localparam int unsigned HWIRQ_N  = 6;
    localparam int unsigned SWIRQ_N  = 2;
    localparam int unsigned IRQ_N    = HWIRQ_N + SWIRQ_N;
    localparam int unsigned STACK_W  = 6;

    localparam logic [REGNO_W-1:0] REGNO_MODE   = 5'd12;
    localparam logic [REGNO_W-1:0] REGNO_REASON = 5'd13;
    localparam logic [REGNO_W-1:0] REGNO_RETPC  = 5'd14;

    localparam logic [WORD_W-1:0] MODE_WMASK  = 32'hF27F_FF3F;
    localparam logic [WORD_W-1:0] MODE_RESET  = 32'h0040_0000;
    localparam int unsigned       BOOTSEL_BIT = 22;

    localparam logic [WORD_W-1:0] VEC_BASE_NORMAL = 32'h8000_0000;
    localparam logic [WORD_W-1:0] VEC_BASE_BOOT   = 32'hBFC0_0100;
    localparam logic [WORD_W-1:0] VEC_OFS_GENERAL = 32'h0000_0080;

    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] code;
        logic [WORD_W-1:0] pc;
        logic              in_delay;
        logic [1:0]        cop;
    } trap_req_t;

    typedef struct packed {
        logic              bd;
        logic [1:0]        cop;
        logic [HWIRQ_N-1:0] hw_pend;
        logic [SWIRQ_N-1:0] sw_pend;
        logic [CODE_W-1:0] code;
    } reason_t;

    typedef enum logic [1:0] {STK_HOLD, STK_PUSH, STK_POP} stack_op_t;

    function automatic logic [STACK_W-1:0] stack_push(input logic [STACK_W-1:0] s);
        return {s[STACK_W-3:0], 2'b00};
    endfunction

    function automatic logic [STACK_W-1:0] stack_pop(input logic [STACK_W-1:0] s);
        return {s[STACK_W-1:STACK_W-2], s[STACK_W-1:2]};
    endfunction

    function automatic logic [WORD_W-1:0] reason_word(input reason_t r);
        logic [WORD_W-1:0] w;
        w        = '0;
        w[31]    = r.bd;
        w[29:28] = r.cop;
        w[15:10] = r.hw_pend;
        w[9:8]   = r.sw_pend;
        w[6:2]   = r.code;
        return w;
    endfunction
endpackage

// File: rtl/exc_mode_reg.sv
module exc_mode_reg
    import exc_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  stack_op_t         op,
    input  logic              sw_wr,
    input  logic [WORD_W-1:0] sw_data,
    output logic [WORD_W-1:0] mode_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RESET;
        end else begin
            unique case (op)
                STK_PUSH: mode_q[STACK_W-1:0] <= stack_push(mode_q[STACK_W-1:0]);
                STK_POP:  mode_q[STACK_W-1:0] <= stack_pop(mode_q[STACK_W-1:0]);
                default: begin
                    if (sw_wr) mode_q <= sw_data & MODE_WMASK;
                end
            endcase
        end
    end

    a_r4_push_shift: assert property (@(posedge clk) disable iff (rst)
        op == STK_PUSH |=> mode_q[5:0] == {$past(mode_q[3:0]), 2'b00}
                           && mode_q[31:6] == $past(mode_q[31:6]));
    a_r7_pop_shift: assert property (@(posedge clk) disable iff (rst)
        op == STK_POP |=> mode_q[3:0] == $past(mode_q[5:2])
                          && mode_q[5:4] == $past(mode_q[5:4]));
    a_r2_mask_zero: assert property (@(posedge clk) disable iff (rst)
        (mode_q & ~MODE_WMASK) == '0);
endmodule

// File: rtl/exc_reason_reg.sv
module exc_reason_reg
    import exc_ctrl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  trap_req_t          trap,
    input  logic               sw_wr,
    input  logic [SWIRQ_N-1:0] sw_bits,
    input  logic [HWIRQ_N-1:0] hw_irq,
    input  logic [IRQ_N-1:0]   irq_mask,
    input  logic               irq_enable,
    output reason_t            reason_q,
    output logic               irq_req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            reason_q <= '0;
        end else begin
            reason_q.hw_pend <= hw_irq;
            if (trap.valid) begin
                reason_q.bd   <= trap.in_delay;
                reason_q.cop  <= trap.cop;
                reason_q.code <= trap.code;
            end else if (sw_wr) begin
                reason_q.sw_pend <= sw_bits;
            end
        end
    end

    assign irq_req = irq_enable && (({reason_q.hw_pend, reason_q.sw_pend} & irq_mask) != '0);

    a_r3_hw_track: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> reason_q.hw_pend == $past(hw_irq));
    a_r5_trap_code: assert property (@(posedge clk) disable iff (rst)
        trap.valid |=> reason_q.code == $past(trap.code) && reason_q.bd == $past(trap.in_delay)
                       && reason_q.cop == $past(trap.cop) && $stable(reason_q.sw_pend));
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
    import exc_ctrl_pkg::*;
(
    input  logic              boot_sel,
    input  logic              user_miss,
    output logic [WORD_W-1:0] vec
);
    logic [WORD_W-1:0] base;
    always_comb begin
        base = boot_sel ? VEC_BASE_BOOT : VEC_BASE_NORMAL;
        vec  = user_miss ? base : (base | VEC_OFS_GENERAL);
    end
endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
    import exc_ctrl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               exc_valid,
    input  logic [CODE_W-1:0]  exc_code,
    input  logic [WORD_W-1:0]  exc_pc,
    input  logic               exc_in_delay,
    input  logic [1:0]         exc_cop,
    input  logic               exc_user_miss,
    input  logic               rfe,
    input  logic               reg_wr,
    input  logic [REGNO_W-1:0] reg_addr,
    input  logic [WORD_W-1:0]  reg_wdata,
    input  logic [HWIRQ_N-1:0] hw_irq,
    output logic [WORD_W-1:0]  reg_rdata,
    output logic               irq_req,
    output logic [WORD_W-1:0]  handler_vec
);
    trap_req_t         trap;
    stack_op_t         op;
    logic [WORD_W-1:0] mode_q;
    reason_t           reason_q;
    logic [WORD_W-1:0] retpc_q;
    logic              wr_mode, wr_reason, wr_retpc;

    always_comb begin
        trap.valid    = exc_valid;
        trap.code     = exc_code;
        trap.pc       = exc_pc;
        trap.in_delay = exc_in_delay;
        trap.cop      = exc_cop;
        if (exc_valid)  op = STK_PUSH;
        else if (rfe)   op = STK_POP;
        else            op = STK_HOLD;
        wr_mode   = reg_wr && !exc_valid && !rfe && reg_addr == REGNO_MODE;
        wr_reason = reg_wr && !exc_valid && !rfe && reg_addr == REGNO_REASON;
        wr_retpc  = reg_wr && !exc_valid && !rfe && reg_addr == REGNO_RETPC;
    end

    exc_mode_reg u_mode (
        .clk(clk), .rst(rst), .op(op), .sw_wr(wr_mode), .sw_data(reg_wdata), .mode_q(mode_q)
    );

    exc_reason_reg u_reason (
        .clk(clk), .rst(rst), .trap(trap), .sw_wr(wr_reason),
        .sw_bits(reg_wdata[9:8]), .hw_irq(hw_irq),
        .irq_mask(mode_q[15:8]), .irq_enable(mode_q[0]),
        .reason_q(reason_q), .irq_req(irq_req)
    );

    exc_vector_sel u_vec (
        .boot_sel(mode_q[BOOTSEL_BIT]), .user_miss(exc_user_miss), .vec(handler_vec)
    );

    always_ff @(posedge clk) begin
        if (rst)              retpc_q <= '0;
        else if (trap.valid)  retpc_q <= trap.in_delay ? trap.pc - WORD_W'(4) : trap.pc;
        else if (wr_retpc)    retpc_q <= reg_wdata;
    end

    always_comb begin
        unique case (reg_addr)
            REGNO_MODE:   reg_rdata = mode_q;
            REGNO_REASON: reg_rdata = reason_word(reason_q);
            REGNO_RETPC:  reg_rdata = retpc_q;
            default:      reg_rdata = '0;
        endcase
    end

    a_r6_retpc: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> retpc_q == ($past(exc_in_delay) ? $past(exc_pc) - 32'd4 : $past(exc_pc)));
    a_r8_irq_needs_ie: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> mode_q[0]);
    a_r10_trap_wins: assert property (@(posedge clk) disable iff (rst)
        exc_valid && rfe |=> mode_q[1:0] == 2'b00);
endmodule

// File: tb/sim_exc_ctrl_unit.sv
module sim_exc_ctrl_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exc_valid = 0;
    logic [4:0]  exc_code = 0;
    logic [31:0] exc_pc = 0;
    logic        exc_in_delay = 0;
    logic [1:0]  exc_cop = 0;
    logic        exc_user_miss = 0;
    logic        rfe = 0;
    logic        reg_wr = 0;
    logic [4:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [5:0]  hw_irq = 0;
    logic [31:0] reg_rdata;
    logic        irq_req;
    logic [31:0] handler_vec;

    int checks = 0;
    int failures = 0;
    string tag = "R1";

    logic [31:0] m_st, m_ca, m_epc;

    always #4 clk = ~clk;

    exc_ctrl_unit u0 (.*);

    // behavioural reference, priority trap > return > write
    always @(posedge clk) begin
        logic [31:0] ns, nc, ne;
        if (rst) begin
            m_st <= 32'h0040_0000; m_ca <= 0; m_epc <= 0;
        end else begin
            ns = m_st; nc = m_ca; ne = m_epc;
            nc[15:10] = hw_irq;
            if (exc_valid) begin
                ns[5:0] = {m_st[3:0], 2'b00};
                nc[31] = exc_in_delay; nc[29:28] = exc_cop; nc[6:2] = exc_code;
                ne = exc_in_delay ? exc_pc - 4 : exc_pc;
            end else if (rfe) begin
                ns[3:0] = m_st[5:2];
            end else if (reg_wr) begin
                if (reg_addr == 12) ns = reg_wdata & 32'hF27F_FF3F;
                else if (reg_addr == 13) nc[9:8] = reg_wdata[9:8];
                else if (reg_addr == 14) ne = reg_wdata;
            end
            m_st <= ns; m_ca <= nc; m_epc <= ne;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic compare();
        logic [31:0] er, ev;
        logic ei;
        er = (reg_addr == 12) ? m_st : (reg_addr == 13) ? m_ca : (reg_addr == 14) ? m_epc : 32'h0;
        ei = m_st[0] && ((m_ca[15:8] & m_st[15:8]) != 0);
        ev = m_st[22] ? (exc_user_miss ? 32'hBFC0_0100 : 32'hBFC0_0180)
                      : (exc_user_miss ? 32'h8000_0000 : 32'h8000_0080);
        chk(tag, reg_rdata, er);
        chk("R8", {31'b0, irq_req}, {31'b0, ei});
        chk("R9", handler_vec, ev);
    endtask

    // drive one cycle of inputs at the falling edge, compare, then let the edge pass
    task automatic cyc(input string t, input logic ex, input logic [4:0] code, input logic [31:0] pc,
                       input logic dly, input logic [1:0] cop, input logic um, input logic rf,
                       input logic wr, input logic [4:0] a, input logic [31:0] wd);
        @(negedge clk);
        tag = t;
        exc_valid = ex; exc_code = code; exc_pc = pc; exc_in_delay = dly; exc_cop = cop;
        exc_user_miss = um; rfe = rf; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        #1 compare();
    endtask

    task automatic rd(input string t, input logic [4:0] a);
        cyc(t, 0, 0, 0, 0, 0, 0, 0, 0, a, 0);
    endtask

    task automatic wr(input string t, input logic [4:0] a, input logic [31:0] d);
        cyc(t, 0, 0, 0, 0, 0, 0, 0, 1, a, d);
    endtask

    task automatic trap(input string t, input logic [4:0] code, input logic [31:0] pc,
                        input logic dly, input logic [1:0] cop);
        cyc(t, 1, code, pc, dly, cop, 0, 0, 0, 14, 0);
    endtask

    task automatic read_all(input string t);
        rd(t, 12); rd(t, 13); rd(t, 14);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1 reset values
        read_all("R1");
        chk("R1", {31'b0, irq_req}, 32'h0);
        // R2 masked status write
        wr("R2", 12, 32'hFFFF_FFFF); rd("R2", 12);
        chk("R2", reg_rdata, 32'hF27F_FF3F);
        wr("R2", 12, 32'h0000_0C3D); rd("R2", 12);
        // R3 software pending bits and hardware tracking
        wr("R3", 13, 32'hFFFF_FFFF); rd("R3", 13);
        chk("R3", reg_rdata & 32'hB000_FC7C, 32'h0);
        hw_irq = 6'b000001; rd("R3", 13); rd("R3", 13);
        hw_irq = 6'b100100; rd("R3", 13);
        // R8 interrupt masking
        wr("R8", 13, 32'h0); rd("R8", 13);
        hw_irq = 6'b000011; rd("R8", 13); rd("R8", 13);
        wr("R8", 12, 32'h0000_0401); rd("R8", 12); rd("R8", 12);
        hw_irq = 0; rd("R8", 13); rd("R8", 13);
        wr("R8", 13, 32'h0000_0100); wr("R8", 12, 32'h0000_0101); rd("R8", 13);
        // R4 R5 R6 trap entry, nested
        wr("R4", 12, 32'h0000_000F);
        trap("R5", 5'd4, 32'h0000_1000, 0, 2'd0); read_all("R4");
        trap("R6", 5'd12, 32'h0000_2008, 1, 2'd3); read_all("R5");
        trap("R6", 5'd11, 32'h0000_0004, 1, 2'd2); read_all("R6");
        // R7 return pops
        wr("R7", 12, 32'h0000_002B);
        cyc("R7", 0, 0, 0, 0, 0, 0, 1, 0, 12, 0); rd("R7", 12);
        cyc("R7", 0, 0, 0, 0, 0, 0, 1, 0, 12, 0); rd("R7", 12);
        // R9 vectors
        wr("R9", 12, 32'h0040_0000); cyc("R9", 0, 0, 0, 0, 0, 1, 0, 0, 12, 0);
        chk("R9", handler_vec, 32'hBFC0_0100);
        wr("R9", 12, 32'h0); cyc("R9", 0, 0, 0, 0, 0, 1, 0, 0, 12, 0);
        chk("R9", handler_vec, 32'h8000_0000);
        cyc("R9", 0, 0, 0, 0, 0, 0, 0, 0, 12, 0);
        chk("R9", handler_vec, 32'h8000_0080);
        // R10 collisions
        wr("R10", 12, 32'h0000_0015);
        cyc("R10", 1, 5'd8, 32'h0000_3000, 0, 0, 0, 0, 1, 12, 32'h0000_0003); read_all("R10");
        wr("R10", 13, 32'h0);
        cyc("R10", 1, 5'd9, 32'h0000_3100, 0, 1, 0, 0, 1, 13, 32'h0000_0300); read_all("R10");
        cyc("R10", 1, 5'd10, 32'h0000_3200, 0, 0, 0, 0, 1, 14, 32'hDEAD_BEEF); read_all("R10");
        wr("R10", 12, 32'h0000_0014);
        cyc("R10", 1, 5'd1, 32'h0000_3300, 0, 0, 0, 1, 0, 12, 0); read_all("R10");
        cyc("R10", 0, 0, 0, 0, 0, 0, 1, 1, 12, 32'h0000_003F); read_all("R10");
        // R11 unmapped registers
        wr("R11", 5'd5, 32'hFFFF_FFFF); rd("R11", 5'd5);
        chk("R11", reg_rdata, 32'h0);
        wr("R11", 5'd0, 32'hFFFF_FFFF); wr("R11", 5'd31, 32'hFFFF_FFFF); read_all("R11");
        // R12 return-address write
        wr("R12", 14, 32'h1234_5679); rd("R12", 14);
        chk("R12", reg_rdata, 32'h1234_5679);
        // R1 reset re-applied
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        read_all("R1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule